// File: doc/BRIEF.md
# Mod-3 Residue Multiply Checker

This block watches a 32x32 to 64-bit multiplier from the side and flags products that cannot be right. It reduces each operand and the product to its residue modulo 3, multiplies the two operand residues modulo 3, and compares that value with the product residue. A mismatch means the product is wrong. The check is modular, so any corruption that moves the product by a multiple of 3 escapes. Any single-bit flip changes the residue, so it is always caught.

Residues are computed by trees of 2-bit end-around-carry adders over 2-bit slices of the word. Every slice carries weight 2^(2k), which is 1 modulo 3. A residue of zero can appear as 00 or as 11, and every comparison treats the two as equal. The 64-bit product residue comes from two 32-bit generators joined by a small modulo-3 adder. A spare adder of the same kind lets the two operand generators take over the product. A self-test request therefore runs the same check a second time, in the following cycle, with the operand generators and product generators trading roles. The block then compares the two sets of residues to expose a fault inside the checker itself.

Top module: `mod3_mul_checker`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, both flags are low.
- R2: A transaction accepted at edge T (valid_i high, block not in its swapped pass) sets chk_err_o for the cycle after T exactly when (prod_i mod 3) differs from ((opa_i*opb_i) mod 3). Otherwise chk_err_o is low for that cycle.
- R3: For a correct product, inverting any single one of the 64 product bits raises chk_err_o.
- R4: Residues equal to zero that are encoded as 11 (for example an all-ones operand) compare equal to zero encoded as 00, so no error is raised for a correct product.
- R5: When valid_i is low at an edge, chk_err_o is low in the following cycle, whatever the data inputs hold.
- R6: A transaction with selftest_i high is checked exactly as in R2, with chk_err_o in the cycle after acceptance.
- R7: The cycle after a self-test acceptance is the swapped pass. Its comparison appears on st_mismatch_o one cycle later, two cycles after acceptance, and is low for a fault-free checker. st_mismatch_o is low at every other time.
- R8: A valid_i arriving during the swapped pass is dropped: chk_err_o stays low for it even if its product is wrong. The next cycle accepts again.
- R9: A product that is off by a multiple of 3 (for example the true product plus 3) does not raise chk_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands and product are present this cycle |
| selftest_i | input | 1 | Run a swapped-hardware self-test pass after this check |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| prod_i | input | 64 | Product to be checked |
| chk_err_o | output | 1 | Registered: product residue disagrees with operand residues |
| st_mismatch_o | output | 1 | Registered: the two self-test passes disagree |

## Verification
The product check and the first pass of a self-test share one cycle and one set of generators. A self-test request whose product is corrupted must therefore raise chk_err_o one cycle later and still leave st_mismatch_o low one cycle after that. The bench provokes this with both correct and corrupted products in self-test mode, and follows each with a corrupted transaction placed in the swapped pass. Each outcome is judged against a residue model in the bench: the corrupted transaction must be dropped, and the transaction after it must be accepted again.

// File: rtl/mod3_pkg.sv
package mod3_pkg;

  typedef logic [1:0] res_t;

  typedef enum logic {
    PH_DIRECT = 1'b0,
    PH_SWAP   = 1'b1
  } phase_e;

  // end-around-carry adder: result stays in 0..3, 3 being a second zero
  function automatic res_t mod3_add(input res_t a, input res_t b);
    logic [2:0] s;
    logic [2:0] f;
    s = {1'b0, a} + {1'b0, b};
    f = {1'b0, s[1:0]} + {2'b00, s[2]};
    return f[1:0];
  endfunction

  function automatic res_t mod3_norm(input res_t r);
    return (r == 2'd3) ? 2'd0 : r;
  endfunction

  function automatic res_t mod3_mul(input res_t a, input res_t b);
    logic [3:0] p;
    p = {2'b00, mod3_norm(a)} * {2'b00, mod3_norm(b)};
    return (p >= 4'd3) ? res_t'(p - 4'd3) : res_t'(p);
  endfunction

  function automatic logic mod3_eq(input res_t a, input res_t b);
    return mod3_norm(a) == mod3_norm(b);
  endfunction

endpackage

// File: rtl/mod3_resgen.sv
module mod3_resgen
  import mod3_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] din,
  output res_t             res_o
);
  // WIDTH/2 must be a power of two
  localparam int SLICES = WIDTH / 2;
  localparam int LEVELS = $clog2(SLICES);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = SLICES >> l;
    res_t v [CNT];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < CNT; i++) begin : g_slice
        assign v[i] = din[2*i +: 2];
      end
    end else begin : g_node
      for (genvar i = 0; i < CNT; i++) begin : g_add
        assign v[i] = mod3_add(g_lvl[l-1].v[2*i], g_lvl[l-1].v[2*i+1]);
      end
    end
  end

  assign res_o = g_lvl[LEVELS].v[0];
endmodule

// File: rtl/mod3_fold.sv
module mod3_fold
  import mod3_pkg::*;
(
  input  res_t a,
  input  res_t b,
  output res_t sum_o
);
  assign sum_o = mod3_add(a, b);
endmodule

// File: rtl/mod3_verdict.sv
module mod3_verdict
  import mod3_pkg::*;
(
  input  res_t rx,
  input  res_t ry,
  input  res_t rp,
  output logic bad_o
);
  res_t expect_r;
  assign expect_r = mod3_mul(rx, ry);
  assign bad_o    = !mod3_eq(expect_r, rp);
endmodule

// File: rtl/mod3_mul_checker.sv
module mod3_mul_checker
  import mod3_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic              selftest_i,
  input  logic [OP_W-1:0]   opa_i,
  input  logic [OP_W-1:0]   opb_i,
  input  logic [2*OP_W-1:0] prod_i,
  output logic              chk_err_o,
  output logic              st_mismatch_o
);
  localparam int PW = 2 * OP_W;

  phase_e            phase_q;
  logic              swap;
  logic              accept;
  logic [OP_W-1:0]   opa_q, opb_q;
  logic [PW-1:0]     prod_q;
  res_t              snap_x, snap_y, snap_p;

  logic [OP_W-1:0]   ga_in, gb_in, gl_in, gh_in;
  res_t              ra, rb, rl, rh;
  res_t              rp_main, rp_spare;
  logic              bad_main;
  logic              pass_diff;

  assign swap   = (phase_q == PH_SWAP);
  assign accept = valid_i && !swap;

  // role steering: direct pass reads the ports, swapped pass reads the captures
  assign ga_in = swap ? prod_q[OP_W-1:0]  : opa_i;
  assign gb_in = swap ? prod_q[PW-1:OP_W] : opb_i;
  assign gl_in = swap ? opa_q : prod_i[OP_W-1:0];
  assign gh_in = swap ? opb_q : prod_i[PW-1:OP_W];

  mod3_resgen #(.WIDTH(OP_W)) u_gen_a  (.din(ga_in), .res_o(ra));
  mod3_resgen #(.WIDTH(OP_W)) u_gen_b  (.din(gb_in), .res_o(rb));
  mod3_resgen #(.WIDTH(OP_W)) u_gen_lo (.din(gl_in), .res_o(rl));
  mod3_resgen #(.WIDTH(OP_W)) u_gen_hi (.din(gh_in), .res_o(rh));

  mod3_fold u_fold_main  (.a(rl), .b(rh), .sum_o(rp_main));
  mod3_fold u_fold_spare (.a(ra), .b(rb), .sum_o(rp_spare));

  mod3_verdict u_verdict (.rx(ra), .ry(rb), .rp(rp_main), .bad_o(bad_main));

  // swapped pass: operand residues from product generators, product from operand generators
  assign pass_diff = !mod3_eq(snap_x, rl) || !mod3_eq(snap_y, rh) ||
                     !mod3_eq(snap_p, rp_spare);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q       <= PH_DIRECT;
      chk_err_o     <= 1'b0;
      st_mismatch_o <= 1'b0;
    end else begin
      phase_q       <= (accept && selftest_i) ? PH_SWAP : PH_DIRECT;
      chk_err_o     <= accept && bad_main;
      st_mismatch_o <= swap && pass_diff;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && selftest_i) begin
      opa_q  <= opa_i;
      opb_q  <= opb_i;
      prod_q <= prod_i;
      snap_x <= ra;
      snap_y <= rb;
      snap_p <= rp_main;
    end
  end
endmodule

// File: rtl/mod3_mul_checker_sva.sv
module mod3_mul_checker_sva (
  input logic clk,
  input logic rst,
  input logic valid_i,
  input logic selftest_i,
  input logic chk_err_o,
  input logic st_mismatch_o,
  input logic swap_phase
);
  // R1: flags clear following a reset edge
  a_r1_clear_after_reset: assert property (@(posedge clk)
    rst |=> (!chk_err_o && !st_mismatch_o));

  // R5: no error flag without a valid in the previous cycle
  a_r5_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !chk_err_o);

  // R8: a valid landing in the swapped pass yields no error flag
  a_r8_swap_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (valid_i && swap_phase) |=> !chk_err_o);

  // R7: the swapped pass follows a self-test acceptance
  a_r7_swap_origin: assert property (@(posedge clk) disable iff (rst)
    (valid_i && selftest_i && !swap_phase) |=> swap_phase);

  // R7: mismatch flag only right after a swapped pass
  a_r7_mismatch_timing: assert property (@(posedge clk) disable iff (rst)
    st_mismatch_o |-> $past(swap_phase));

  // R7: fault-free checker never reports disagreement
  a_r7_no_mismatch: assert property (@(posedge clk) disable iff (rst)
    !st_mismatch_o);
endmodule

bind mod3_mul_checker mod3_mul_checker_sva u_sva (
  .clk(clk),
  .rst(rst),
  .valid_i(valid_i),
  .selftest_i(selftest_i),
  .chk_err_o(chk_err_o),
  .st_mismatch_o(st_mismatch_o),
  .swap_phase(swap)
);

// File: tb/mod3_mul_checker_tb.sv
module mod3_mul_checker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic        selftest_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [63:0] prod_i = '0;
  logic        chk_err_o;
  logic        st_mismatch_o;

  int checks = 0;
  int errors = 0;

  mod3_mul_checker u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .selftest_i(selftest_i),
    .opa_i(opa_i), .opb_i(opb_i), .prod_i(prod_i),
    .chk_err_o(chk_err_o), .st_mismatch_o(st_mismatch_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] true_prod(input logic [31:0] a, input logic [31:0] b);
    return {32'd0, a} * {32'd0, b};
  endfunction

  function automatic logic model_err(input logic [31:0] a, input logic [31:0] b,
                                     input logic [63:0] p);
    return (p % 64'd3) != (true_prod(a, b) % 64'd3);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic st, input logic [31:0] a,
                       input logic [31:0] b, input logic [63:0] p);
    valid_i = v; selftest_i = st; opa_i = a; opb_i = b; prod_i = p;
  endtask

  // normal transaction: drive at negedge, result visible by next negedge
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] p);
    @(negedge clk);
    drive(1'b1, 1'b0, a, b, p);
    @(negedge clk);
    drive(1'b0, 1'b0, '0, '0, '0);
    check(req, chk_err_o, model_err(a, b, p));
    check(req, st_mismatch_o, 1'b0);
  endtask

  // self-test, with an optional wrong-product valid placed in the swapped pass
  task automatic run_self(input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] p, input logic intrude);
    @(negedge clk);
    drive(1'b1, 1'b1, a, b, p);
    @(negedge clk);
    check("R6", chk_err_o, model_err(a, b, p));
    if (intrude) drive(1'b1, 1'b0, 32'd5, 32'd7, 64'd36);
    else         drive(1'b0, 1'b0, '0, '0, '0);
    @(negedge clk);
    drive(1'b0, 1'b0, '0, '0, '0);
    check("R7", st_mismatch_o, 1'b0);
    check("R8", chk_err_o, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    logic [63:0] p;
    void'($urandom(32'd4242));
    // R1: flags low in reset and just after release, even with bad data applied
    drive(1'b1, 1'b0, 32'd2, 32'd2, 64'd5);
    repeat (3) @(negedge clk);
    check("R1", chk_err_o, 1'b0);
    check("R1", st_mismatch_o, 1'b0);
    rst = 1'b0;
    drive(1'b0, 1'b0, '0, '0, '0);
    @(negedge clk);
    check("R1", chk_err_o, 1'b0);
    check("R1", st_mismatch_o, 1'b0);

    // R2 directed
    run_op("R2", 32'd6, 32'd7, 64'd42);
    run_op("R2", 32'd6, 32'd7, 64'd43);
    run_op("R2", 32'd2, 32'd2, 64'd5);

    // R4: all-ones operands and slices of 11 (zero residues in the second encoding)
    a = 32'hFFFF_FFFF;
    run_op("R4", a, a, true_prod(a, a));
    run_op("R4", 32'd3, 32'd1, 64'd3);
    run_op("R4", 32'd0, 32'hDEAD_BEEF, 64'd0);
    run_op("R4", 32'hFFFF_FFFF, 32'd1, 64'h0000_0000_FFFF_FFFF);

    // R9: off by a multiple of 3 escapes, off by 1 does not
    p = true_prod(32'd123457, 32'd98765);
    run_op("R9", 32'd123457, 32'd98765, p + 64'd3);
    run_op("R9", 32'd123457, 32'd98765, p - 64'd6);
    run_op("R2", 32'd123457, 32'd98765, p + 64'd1);

    // R3: every single-bit flip of a correct product
    a = $urandom; b = $urandom;
    p = true_prod(a, b);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      drive(1'b1, 1'b0, a, b, p ^ (64'd1 << k));
      @(negedge clk);
      drive(1'b0, 1'b0, '0, '0, '0);
      check("R3", chk_err_o, 1'b1);
    end

    // R5: no valid, wrong data
    @(negedge clk);
    drive(1'b0, 1'b0, 32'd4, 32'd4, 64'd17);
    @(negedge clk);
    check("R5", chk_err_o, 1'b0);
    drive(1'b0, 1'b0, '0, '0, '0);

    // R2 random mixes of correct and corrupted products
    for (int n = 0; n < 300; n++) begin
      a = $urandom; b = $urandom;
      p = true_prod(a, b);
      case ($urandom % 4)
        0: p = p ^ ({$urandom, $urandom});
        1: p = p + 64'($urandom % 8);
        default: ;
      endcase
      run_op("R2", a, b, p);
    end

    // R6, R7, R8: self-test with correct and corrupted products
    run_self(32'd9, 32'd11, 64'd99, 1'b0);
    run_self(32'd9, 32'd11, 64'd100, 1'b1);
    a = 32'hFFFF_FFFF;
    run_self(a, a, true_prod(a, a), 1'b1);
    // R8: accepted again right after the swapped pass
    run_op("R8", 32'd5, 32'd7, 64'd36);
    for (int n = 0; n < 60; n++) begin
      a = $urandom; b = $urandom;
      p = true_prod(a, b);
      if (n % 2 == 1) p = p ^ (64'd1 << ($urandom % 64));
      run_self(a, b, p, 1'(n % 3 == 0));
    end

    // back-to-back normal transactions
    @(negedge clk);
    drive(1'b1, 1'b0, 32'd3, 32'd3, 64'd10);
    @(negedge clk);
    check("R2", chk_err_o, 1'b1);
    drive(1'b1, 1'b0, 32'd3, 32'd3, 64'd9);
    @(negedge clk);
    check("R2", chk_err_o, 1'b0);
    drive(1'b0, 1'b0, '0, '0, '0);
    @(negedge clk);
    check("R5", chk_err_o, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule